// File: doc/BRIEF.md
# Limit-Period Match Timer Core

This block is a timing core for pulse-width generation. It runs one 32-bit up-counter that sixteen match comparators watch. Each of sixteen event slots picks one match register and emits a one-tick pulse whenever the counter equals that register. A limit mask says which event slots end the period: when any of them fires, the counter returns to zero on the next count. Downstream output logic uses the 16-bit event vector to set or clear its pins.

The period is not held in a register of its own. It comes from whichever match register a limit-flagged event watches, so a period of N ticks is programmed as N-1. Every match register has a reload register behind it. New values written there are copied in only on the tick where a limit event resets the counter, so duty and period changes land on period boundaries. A config bit turns this copying off. Counting needs the unified-mode bit set and the halt bit clear. An 8-bit prescaler gives one count per PRE+1 clocks.

Software reaches all state through a simple write strobe and a combinational read port that use byte addresses.

Top module: `match_timer_core`

## Requirements
- R1: After reset, the control word at 0x004 reads 0x4 (halt set, prescaler 0). Every other register reads 0 and the event vector is 0.
- R2: With config bit 0 (unify) set and control bit 2 (halt) clear, the counter advances by one every PRE+1 clocks. PRE is control bits 12:5.
- R3: Event slot n has its control word at 0x304+8n and its state mask at 0x300+8n. The slot pulses its event bit for one clock on a count tick when the counter equals the match register chosen by control bits 3:0, control bits 13:12 equal 01, and state-mask bit 0 is set.
- R4: When an event whose bit is set in the 16-bit limit mask at 0x008 fires, the counter becomes 0 on that tick instead of incrementing. A match value of P therefore gives a period of P+1 ticks.
- R5: While halt is set or unify is clear, the counter does not move and no event fires.
- R6: An event slot whose control bits 13:12 are not 01, or whose state-mask bit 0 is clear, never fires. This includes a control word of zero.
- R7: Writing reload register n (0x200+4n) leaves match register n (0x100+4n) unchanged until the next limit-event tick. If reload is enabled, the match register takes the reload value on that tick.
- R8: While config bit 7 is set, limit events do not copy the reload registers into the match registers.
- R9: The config, control, limit, match, reload, event-control and state-mask registers read back what was written to their fields.
- R10: With an empty limit mask the counter runs past every match value without returning to zero, so each event fires at most once in a window shorter than the counter range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Byte address for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| eventVec | output | 16 | One-clock event pulses, one bit per slot |

## Verification
The period and event path is tested with a table of settings that vary the prescaler, the period match and the duty match. The table includes a duty equal to the period, a duty of zero and a period of one tick. Counting the pulses in fixed windows checks the tick rate, the limit reset and that coincident events fire together. Separate directed runs cover:
- halt and a cleared unify bit, which freeze counting;
- disarmed event slots, which stay silent while an armed slot on the same match fires;
- reload registers, which take effect only after a period boundary, and the no-reload bit, which blocks this;
- an empty limit mask, which lets the counter run on past the period.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic tick;    // one count step
    logic clear;   // a limit event fired on this tick
    logic reload;  // copy reload registers into match registers
  } mtcStrobe_t;

  localparam int CFG_UNIFY    = 0;
  localparam int CFG_NORELOAD = 7;
  localparam int CTRL_HALT    = 2;
  localparam int CTRL_PRE_LSB = 5;
  localparam int EVC_MODE_LSB = 12;
  localparam logic [1:0] MODE_MATCH = 2'b01;

  localparam logic [3:0] RGN_TOP    = 4'h0;
  localparam logic [3:0] RGN_MATCH  = 4'h1;
  localparam logic [3:0] RGN_RELOAD = 4'h2;
  localparam logic [3:0] RGN_EVENT  = 4'h3;

  localparam logic [7:0] OFS_CFG   = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_LIMIT = 8'h08;
endpackage

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
  import mtc_pkg::*;
#(
  parameter int NUM_EV    = 16,
  parameter int NUM_MATCH = 16,
  parameter int PRE_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  localparam int SEL_W    = $clog2(NUM_MATCH),
  localparam int IDX_W    = $clog2(NUM_EV)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_EV-1:0] evHit,
  output mtcStrobe_t        strb,
  output logic [SEL_W-1:0]  evSel [NUM_EV],
  output logic [NUM_EV-1:0] evArm,
  output logic [NUM_EV-1:0] evOut,
  output logic              haltBit,
  output logic [DATA_W-1:0] rdData
);
  localparam int RGN_W = ADDR_W - 8;

  logic [RGN_W-1:0] rgn;
  logic [7:0]       ofs;
  logic [IDX_W-1:0] evIdx;
  logic             inTop, inEv;

  assign rgn   = addr[ADDR_W-1:8];
  assign ofs   = addr[7:0];
  assign evIdx = addr[IDX_W+2:3];
  assign inTop = (rgn == RGN_W'(RGN_TOP));
  assign inEv  = (rgn == RGN_W'(RGN_EVENT));

  logic              cfgUnify, cfgNoReload, ctrlHalt;
  logic [PRE_W-1:0]  ctrlPre, preCnt;
  logic [NUM_EV-1:0] limitMask;
  logic [DATA_W-1:0] evCtrl [NUM_EV];
  logic [DATA_W-1:0] evMask [NUM_EV];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgUnify    <= 1'b0;
      cfgNoReload <= 1'b0;
      ctrlHalt    <= 1'b1;
      ctrlPre     <= '0;
      limitMask   <= '0;
    end else if (wrEn && inTop) begin
      case (ofs)
        OFS_CFG: begin
          cfgUnify    <= wrData[CFG_UNIFY];
          cfgNoReload <= wrData[CFG_NORELOAD];
        end
        OFS_CTRL: begin
          ctrlHalt <= wrData[CTRL_HALT];
          ctrlPre  <= wrData[CTRL_PRE_LSB +: PRE_W];
        end
        OFS_LIMIT: limitMask <= wrData[NUM_EV-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rstN) begin
        evCtrl[i] <= '0;
        evMask[i] <= '0;
      end else if (wrEn && inEv && evIdx == IDX_W'(i)) begin
        if (addr[2]) evCtrl[i] <= wrData;
        else         evMask[i] <= wrData;
      end
    end
    assign evSel[i] = evCtrl[i][SEL_W-1:0];
    assign evArm[i] = (evCtrl[i][EVC_MODE_LSB +: 2] == MODE_MATCH) && evMask[i][0];
  end

  // prescaler: one tick every ctrlPre+1 clocks while running
  logic running, tick;
  assign running = cfgUnify && !ctrlHalt;
  assign tick    = running && (preCnt == ctrlPre);

  always_ff @(posedge clk) begin
    if (!rstN)                preCnt <= '0;
    else if (!running || tick) preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  assign strb.tick   = tick;
  assign strb.clear  = tick && |(evHit & limitMask);
  assign strb.reload = strb.clear && !cfgNoReload;
  assign evOut       = evHit & {NUM_EV{tick}};
  assign haltBit     = ctrlHalt;

  always_comb begin
    rdData = '0;
    if (inTop) begin
      case (ofs)
        OFS_CFG: begin
          rdData[CFG_UNIFY]    = cfgUnify;
          rdData[CFG_NORELOAD] = cfgNoReload;
        end
        OFS_CTRL: begin
          rdData[CTRL_HALT]              = ctrlHalt;
          rdData[CTRL_PRE_LSB +: PRE_W]  = ctrlPre;
        end
        OFS_LIMIT: rdData[NUM_EV-1:0] = limitMask;
        default: ;
      endcase
    end else if (inEv) begin
      rdData = addr[2] ? evCtrl[evIdx] : evMask[evIdx];
    end
  end

  logic unusedBits;
  assign unusedBits = ^{addr[1:0], addr[7:IDX_W+3]};
endmodule

// File: rtl/mtc_data.sv
module mtc_data
  import mtc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_EV    = 16,
  parameter int NUM_MATCH = 16,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  localparam int SEL_W    = $clog2(NUM_MATCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  mtcStrobe_t        strb,
  input  logic [SEL_W-1:0]  evSel [NUM_EV],
  input  logic [NUM_EV-1:0] evArm,
  output logic [NUM_EV-1:0] evHit,
  output logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] rdData
);
  localparam int RGN_W = ADDR_W - 8;

  logic [RGN_W-1:0] rgn;
  logic [SEL_W-1:0] mIdx;
  logic             inMatch, inReload;

  assign rgn      = addr[ADDR_W-1:8];
  assign mIdx     = addr[SEL_W+1:2];
  assign inMatch  = (rgn == RGN_W'(RGN_MATCH));
  assign inReload = (rgn == RGN_W'(RGN_RELOAD));

  logic [CNT_W-1:0] matchReg  [NUM_MATCH];
  logic [CNT_W-1:0] reloadReg [NUM_MATCH];

  always_ff @(posedge clk) begin
    if (!rstN)          cntVal <= '0;
    else if (strb.tick) cntVal <= strb.clear ? '0 : cntVal + 1'b1;
  end

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchReg[m]  <= '0;
        reloadReg[m] <= '0;
      end else begin
        // a bus write takes priority over a boundary reload
        if (wrEn && inMatch && mIdx == SEL_W'(m)) matchReg[m] <= wrData[CNT_W-1:0];
        else if (strb.reload)                     matchReg[m] <= reloadReg[m];
        if (wrEn && inReload && mIdx == SEL_W'(m)) reloadReg[m] <= wrData[CNT_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_cmp
    assign evHit[i] = evArm[i] && (cntVal == matchReg[evSel[i]]);
  end

  always_comb begin
    rdData = '0;
    if (inMatch)       rdData = DATA_W'(matchReg[mIdx]);
    else if (inReload) rdData = DATA_W'(reloadReg[mIdx]);
  end

  logic unusedBits;
  assign unusedBits = ^{addr[1:0], addr[7:SEL_W+2], wrData};
endmodule

// File: rtl/match_timer_core.sv
module match_timer_core
  import mtc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_EV    = 16,
  parameter int NUM_MATCH = 16,
  parameter int PRE_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_EV-1:0] eventVec
);
  localparam int SEL_W = $clog2(NUM_MATCH);

  mtcStrobe_t        strb;
  logic [SEL_W-1:0]  evSel [NUM_EV];
  logic [NUM_EV-1:0] evArm, evHit;
  logic [CNT_W-1:0]  cntVal;
  logic              haltBit;
  logic [DATA_W-1:0] ctrlRd, dataRd;

  mtc_ctrl #(
    .NUM_EV(NUM_EV), .NUM_MATCH(NUM_MATCH), .PRE_W(PRE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .evHit(evHit), .strb(strb), .evSel(evSel), .evArm(evArm),
    .evOut(eventVec), .haltBit(haltBit), .rdData(ctrlRd)
  );

  mtc_data #(
    .CNT_W(CNT_W), .NUM_EV(NUM_EV), .NUM_MATCH(NUM_MATCH),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .evSel(evSel), .evArm(evArm), .evHit(evHit),
    .cntVal(cntVal), .rdData(dataRd)
  );

  // each sub-block drives zero outside its own address range
  assign rdData = ctrlRd | dataRd;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker
  import mtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_EV = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_EV-1:0] eventVec,
  input logic [CNT_W-1:0]  cntVal,
  input mtcStrobe_t        strb,
  input logic              haltBit
);
  AST_EVENT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |-> eventVec == '0);                                        // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.clear) |=> cntVal == CNT_W'($past(cntVal) + 1'b1)); // R2
  AST_LIMIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> cntVal == '0);                                          // R4
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(cntVal));                                       // R5
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    haltBit |-> !strb.tick);                                               // R5
  AST_RELOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |-> strb.tick);                                            // R7
endmodule

bind match_timer_core mtc_checker #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_chk (
  .clk(clk), .rstN(rstN), .eventVec(eventVec), .cntVal(cntVal),
  .strb(strb), .haltBit(haltBit)
);

// File: tb/sim_match_timer_core.sv
module sim_match_timer_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] eventVec;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  match_timer_core u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .eventVec(eventVec)
  );

  // pre, period match, duty match, window clocks, expected ev0, expected ev1
  localparam int VEC [4][6] = '{
    '{0, 9, 3, 100, 10, 10},
    '{1, 4, 4,  50,  5,  5},
    '{2, 7, 0,  60,  2,  3},
    '{0, 0, 0,  10, 10, 10}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // slot 0 watches match 0 (period), slot 1 watches match 1 (duty)
  task automatic setupPwm(input int pre, input int per, input int duty);
    doReset();
    wr(12'h000, 32'h1);
    wr(12'h008, 32'h1);
    wr(12'h300, 32'hFFFF_FFFF);
    wr(12'h304, 32'h1000);
    wr(12'h308, 32'hFFFF_FFFF);
    wr(12'h30C, 32'h1001);
    wr(12'h100, per);
    wr(12'h104, duty);
    wr(12'h200, per);
    wr(12'h204, duty);
    wr(12'h004, pre << 5);
  endtask

  task automatic runCount(input int cycles, output int c0, output int c1, output int c2);
    c0 = 0; c1 = 0; c2 = 0;
    for (int k = 0; k < cycles; k++) begin
      c0 += int'(eventVec[0]);
      c1 += int'(eventVec[1]);
      c2 += int'(eventVec[2]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c0, c1, c2;
    logic [31:0] d;

    // R1 reset state
    doReset();
    rd(12'h004, d); check("R1", "ctrl after reset", d, 32'h4);
    rd(12'h000, d); check("R1", "cfg after reset", d, 32'h0);
    rd(12'h104, d); check("R1", "match1 after reset", d, 32'h0);
    check("R1", "events after reset", {16'h0, eventVec}, 32'h0);

    // R9 readback
    wr(12'h008, 32'h0000_A5A5); rd(12'h008, d); check("R9", "limit readback", d, 32'hA5A5);
    wr(12'h004, 32'h0000_1FE4); rd(12'h004, d); check("R9", "ctrl readback", d, 32'h1FE4);
    wr(12'h000, 32'h0000_0081); rd(12'h000, d); check("R9", "cfg readback", d, 32'h81);
    wr(12'h31C, 32'h0000_1003); rd(12'h31C, d); check("R9", "event3 ctrl readback", d, 32'h1003);
    wr(12'h318, 32'h0000_00F1); rd(12'h318, d); check("R9", "event3 mask readback", d, 32'hF1);
    wr(12'h23C, 32'h1234_5678); rd(12'h23C, d); check("R9", "reload15 readback", d, 32'h1234_5678);
    wr(12'h13C, 32'h0BAD_F00D); rd(12'h13C, d); check("R9", "match15 readback", d, 32'h0BAD_F00D);

    // R2 R3 R4 vector table
    for (int v = 0; v < 4; v++) begin
      setupPwm(VEC[v][0], VEC[v][1], VEC[v][2]);
      runCount(VEC[v][3], c0, c1, c2);
      check("R4", $sformatf("R2 period events vec %0d", v), c0, VEC[v][4]);
      check("R3", $sformatf("R2 duty events vec %0d", v), c1, VEC[v][5]);
    end

    // R5 halt freezes
    setupPwm(0, 2, 1);
    runCount(9, c0, c1, c2);
    check("R4", "running before halt", c0, 3);
    wr(12'h004, 32'h4);
    runCount(20, c0, c1, c2);
    check("R5", "events while halted", c0 + c1, 0);

    // R5 unify clear freezes
    setupPwm(0, 2, 1);
    wr(12'h000, 32'h0);
    runCount(20, c0, c1, c2);
    check("R5", "events with unify clear", c0 + c1, 0);

    // R6 disarmed slots, slot 2 watching match 2 (value 0)
    setupPwm(0, 2, 1);
    wr(12'h310, 32'hFFFF_FFFF);
    wr(12'h314, 32'h0);
    runCount(20, c0, c1, c2);
    check("R6", "zero control word", c2, 0);
    wr(12'h314, 32'h2002);
    runCount(20, c0, c1, c2);
    check("R6", "mode not match-only", c2, 0);
    wr(12'h314, 32'h1002);
    wr(12'h310, 32'h0);
    runCount(20, c0, c1, c2);
    check("R6", "state mask bit0 clear", c2, 0);
    wr(12'h310, 32'hFFFF_FFFF);
    runCount(21, c0, c1, c2);
    check("R3", "armed slot fires", c2, 7);

    // R7 reload at boundary
    setupPwm(0, 9, 3);
    wr(12'h204, 32'd6);
    rd(12'h104, d); check("R7", "match before boundary", d, 32'd3);
    runCount(12, c0, c1, c2);
    rd(12'h104, d); check("R7", "match after boundary", d, 32'd6);

    // R8 no reload
    wr(12'h000, 32'h81);
    wr(12'h204, 32'd8);
    runCount(25, c0, c1, c2);
    rd(12'h104, d); check("R8", "match held with reload off", d, 32'd6);

    // R10 empty limit mask
    setupPwm(0, 20, 1);
    wr(12'h008, 32'h0);
    runCount(60, c0, c1, c2);
    check("R10", "period event once", c0, 1);
    check("R10", "duty not revisited", c1, 0);

    summary();
    $finish;
  end
endmodule